// File: doc/BRIEF.md
# Domain Voltage/Frequency Transition Sequencer

This block belongs to one clock domain. It moves the domain from its present operating point (a supply step code and a frequency code) to a requested one. A request carries a target frequency code, a target supply step and a mode bit. Out-of-range targets are clamped to the legal window. The order of the changes depends on their direction:

- **Lowering the frequency:** the new frequency is issued at once, and the supply then walks toward its target.
- **Raising the frequency:** the supply walks first, the last step is allowed to settle, and only then is the frequency raised.

The supply moves one step at a time. Each step is held for a programmable number of cycles, which stands in for the regulator settling time.

The mode bit selects how a frequency change is handled:

- **Relock mode:** the domain is stalled and its clock enable dropped until the PLL reports lock again. The lock time varies, so the sequencer waits on the lock input and never on a fixed delay.
- **Run-through mode:** the domain keeps running through the change and no stall is raised.

While a transition is in progress, `busy` is high. A request that arrives during that time is parked and served once the current transition ends. A one-cycle `done` pulse marks each completed request.

Top module: `dvfs_seq`

## Requirements
- R1: After reset the supply step output is V_MAX (19), the frequency output is F_MAX (6), and stall, busy and done are all low.
- R2: Request codes are clamped before use. A frequency code below F_MIN (1) or above F_MAX (6) becomes the nearer bound. A supply step above V_MAX (19) becomes 19. The outputs never leave these windows.
- R3: When the clamped target frequency is below the current one, `freq_sel` takes the target on the edge that accepts the request, before any supply step.
- R4: When the clamped target frequency is above the current one, `freq_sel` changes only after the supply has reached its target and the last step has been held for its full dwell. The frequency never changes in the same cycle as a supply step.
- R5: `vstep_out` moves by exactly one code per change. Each value reached is held for max(`dwell_cycles`, 1) cycles, the final one included, before the next step or the completion.
- R6: In relock mode, `stall` rises together with a frequency change. It falls only after `pll_locked` has been seen low and then high. `clk_en` is always the inverse of `stall`, and `vstep_out` does not move while `stall` is high.
- R7: In run-through mode, `stall` never goes high.
- R8: `busy` is high from the cycle after a non-trivial request is accepted until completion. `done` is a one-cycle pulse in the cycle `busy` falls. In run-through mode, with n supply steps and dwell d, `done` is high 1 + n*max(d,1) cycles after the accepting edge.
- R9: A request whose clamped target equals the current operating point raises `done` in the cycle after acceptance, with `busy` and `stall` staying low.
- R10: A request that arrives while `busy` is high is held and started after the running transition completes. A later request replaces an earlier held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_freq | input | FREQ_W | Requested frequency code |
| req_vstep | input | VSTEP_W | Requested supply step code |
| req_relock | input | 1 | 1 = relock mode, 0 = run-through mode |
| dwell_cycles | input | DWELL_W | Hold time of each supply step, in cycles |
| pll_locked | input | 1 | Lock indication from the PLL |
| vstep_out | output | VSTEP_W | Supply step code toward the regulator |
| freq_sel | output | FREQ_W | Frequency select toward the PLL |
| stall | output | 1 | Domain stall during relock |
| clk_en | output | 1 | Domain clock enable, inverse of stall |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several properties are checked on every cycle by the assertions:

- The one-code supply movement and the legal output windows.
- The separation between frequency changes and supply steps.
- No supply step during stall, and stall release only under lock.
- A step never settles early after a load.
- `done` is never raised while `busy` is high, and a request that arrives while `busy` is high is parked.

Other behaviour shows only in the bench's scenarios:

- The ordering of changes by direction.
- The exact completion latency.
- The absence of stall in run-through mode.
- Clamping to the final operating point.
- Equal-point requests.
- Replacement of a parked request by a newer one.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_VOLT   = 2'd1,
        ST_RELOCK = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dvfs_clamp.sv
module dvfs_clamp #(
    parameter int W  = 5,
    parameter int LO = 0,
    parameter int HI = 19
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] lim
);
    localparam logic [W-1:0] LO_C = W'(LO);
    localparam logic [W-1:0] HI_C = W'(HI);

    generate
        if (LO > 0) begin : g_two_sided
            always_comb begin
                if (raw < LO_C)      lim = LO_C;
                else if (raw > HI_C) lim = HI_C;
                else                 lim = raw;
            end
        end else begin : g_upper_only
            always_comb begin
                if (raw > HI_C) lim = HI_C;
                else            lim = raw;
            end
        end
    endgenerate
endmodule

// File: rtl/dvfs_dwell_timer.sv
module dvfs_dwell_timer #(
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               arm,
    input  logic [DWELL_W-1:0] dwell_cycles,
    output logic               settled
);
    localparam logic [DWELL_W-1:0] CNT_SAT = '1;
    localparam logic [DWELL_W-1:0] CNT_ONE = DWELL_W'(1);

    logic [DWELL_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)                cnt_d = CNT_ONE;
        else if (arm)            cnt_d = CNT_SAT;
        else if (cnt_q == CNT_SAT) cnt_d = cnt_q;
        else                     cnt_d = cnt_q + CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_SAT;
        else        cnt_q <= cnt_d;
    end

    assign settled = (cnt_q >= dwell_cycles);

    // a freshly loaded step is not settled when the dwell exceeds one cycle
    assert_no_early_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load) && dwell_cycles > CNT_ONE) |-> !settled);
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
    parameter int FREQ_W  = 3,
    parameter int F_MIN   = 1,
    parameter int F_MAX   = 6,
    parameter int VSTEP_W = 5,
    parameter int V_MIN   = 0,
    parameter int V_MAX   = 19,
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [FREQ_W-1:0]  req_freq,
    input  logic [VSTEP_W-1:0] req_vstep,
    input  logic               req_relock,
    input  logic [DWELL_W-1:0] dwell_cycles,
    input  logic               pll_locked,
    output logic [VSTEP_W-1:0] vstep_out,
    output logic [FREQ_W-1:0]  freq_sel,
    output logic               stall,
    output logic               clk_en,
    output logic               busy,
    output logic               done
);
    import dvfs_pkg::*;

    localparam logic [FREQ_W-1:0]  F_TOP = FREQ_W'(F_MAX);
    localparam logic [FREQ_W-1:0]  F_BOT = FREQ_W'(F_MIN);
    localparam logic [VSTEP_W-1:0] V_TOP = VSTEP_W'(V_MAX);
    localparam logic [VSTEP_W-1:0] V_BOT = VSTEP_W'(V_MIN);
    localparam logic [VSTEP_W-1:0] V_ONE = VSTEP_W'(1);

    typedef struct packed {
        seq_state_e         st;
        logic [VSTEP_W-1:0] vstep;
        logic [FREQ_W-1:0]  freq;
        logic [VSTEP_W-1:0] tgt_v;
        logic [FREQ_W-1:0]  tgt_f;
        logic               mode;
        logic               resume;
        logic               seen_low;
        logic               stall;
        logic               busy;
        logic               done;
        logic               pend_vld;
        logic [FREQ_W-1:0]  pend_f;
        logic [VSTEP_W-1:0] pend_v;
        logic               pend_mode;
    } seq_t;

    seq_t q, n;

    logic               src_vld, src_mode;
    logic [FREQ_W-1:0]  src_f, lim_f;
    logic [VSTEP_W-1:0] src_v, lim_v;
    logic               tmr_load, tmr_arm, settled;

    // incoming request wins over a parked one
    always_comb begin
        src_vld  = req_valid | q.pend_vld;
        src_f    = req_valid ? req_freq   : q.pend_f;
        src_v    = req_valid ? req_vstep  : q.pend_v;
        src_mode = req_valid ? req_relock : q.pend_mode;
    end

    dvfs_clamp #(.W(FREQ_W), .LO(F_MIN), .HI(F_MAX)) i_clamp_f (
        .raw (src_f),
        .lim (lim_f)
    );

    dvfs_clamp #(.W(VSTEP_W), .LO(V_MIN), .HI(V_MAX)) i_clamp_v (
        .raw (src_v),
        .lim (lim_v)
    );

    dvfs_dwell_timer #(.DWELL_W(DWELL_W)) i_dwell (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (tmr_load),
        .arm          (tmr_arm),
        .dwell_cycles (dwell_cycles),
        .settled      (settled)
    );

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_arm  = 1'b0;

        if (q.st != ST_IDLE && req_valid) begin
            n.pend_vld  = 1'b1;
            n.pend_f    = req_freq;
            n.pend_v    = req_vstep;
            n.pend_mode = req_relock;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (src_vld) begin
                    n.pend_vld = 1'b0;
                    n.tgt_f    = lim_f;
                    n.tgt_v    = lim_v;
                    n.mode     = src_mode;
                    if (lim_f == q.freq && lim_v == q.vstep) begin
                        n.done = 1'b1;
                    end else begin
                        n.busy = 1'b1;
                        if (lim_f < q.freq) begin
                            n.freq = lim_f;
                            if (src_mode) begin
                                n.st       = ST_RELOCK;
                                n.stall    = 1'b1;
                                n.seen_low = 1'b0;
                                n.resume   = 1'b1;
                            end else begin
                                n.st    = ST_VOLT;
                                tmr_arm = 1'b1;
                            end
                        end else begin
                            n.st    = ST_VOLT;
                            tmr_arm = 1'b1;
                        end
                    end
                end
            end
            ST_VOLT: begin
                if (settled) begin
                    if (q.vstep != q.tgt_v) begin
                        n.vstep  = (q.vstep < q.tgt_v) ? q.vstep + V_ONE : q.vstep - V_ONE;
                        tmr_load = 1'b1;
                    end else if (q.tgt_f != q.freq) begin
                        n.freq = q.tgt_f;
                        if (q.mode) begin
                            n.st       = ST_RELOCK;
                            n.stall    = 1'b1;
                            n.seen_low = 1'b0;
                            n.resume   = 1'b0;
                        end else begin
                            n.st   = ST_IDLE;
                            n.busy = 1'b0;
                            n.done = 1'b1;
                        end
                    end else begin
                        n.st   = ST_IDLE;
                        n.busy = 1'b0;
                        n.done = 1'b1;
                    end
                end
            end
            ST_RELOCK: begin
                if (!pll_locked) n.seen_low = 1'b1;
                if (q.seen_low && pll_locked) begin
                    n.stall = 1'b0;
                    if (q.resume) begin
                        n.st    = ST_VOLT;
                        tmr_arm = 1'b1;
                    end else begin
                        n.st   = ST_IDLE;
                        n.busy = 1'b0;
                        n.done = 1'b1;
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= ST_IDLE;
            q.vstep     <= V_TOP;
            q.freq      <= F_TOP;
            q.tgt_v     <= V_TOP;
            q.tgt_f     <= F_TOP;
        end else begin
            q <= n;
        end
    end

    assign vstep_out = q.vstep;
    assign freq_sel  = q.freq;
    assign stall     = q.stall;
    assign clk_en    = ~q.stall;
    assign busy      = q.busy;
    assign done      = q.done;

    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vstep_out == $past(vstep_out)) || (vstep_out == $past(vstep_out) + V_ONE)
        || (vstep_out == $past(vstep_out) - V_ONE));

    assert_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        freq_sel >= F_BOT && freq_sel <= F_TOP && vstep_out >= V_BOT && vstep_out <= V_TOP);

    assert_freq_apart_from_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_sel != $past(freq_sel)) |-> (vstep_out == $past(vstep_out)));

    assert_no_step_in_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $past(stall)) |-> $stable(vstep_out));

    assert_release_on_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> $past(pll_locked));

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_park_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> q.pend_vld);

    always_comb begin
        assert_clk_en_R6: assert (clk_en != stall);
    end
endmodule

// File: tb/test_dvfs_seq.sv
module test_dvfs_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_freq = '0;
    logic [4:0] req_vstep = '0;
    logic       req_relock = 1'b0;
    logic [15:0] dwell_cycles = 16'd1;
    logic       pll_locked = 1'b1;
    logic [4:0] vstep_out;
    logic [2:0] freq_sel;
    logic       stall, clk_en, busy, done;

    int n_chk = 0, n_err = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dvfs_seq i_dvfs_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_freq(req_freq),
        .req_vstep(req_vstep), .req_relock(req_relock), .dwell_cycles(dwell_cycles),
        .pll_locked(pll_locked), .vstep_out(vstep_out), .freq_sel(freq_sel),
        .stall(stall), .clk_en(clk_en), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // PLL model: lock drops on any frequency change, returns after 5 cycles
    initial begin
        logic [2:0] last_f;
        int lk;
        last_f = 3'd6;
        lk = 0;
        forever begin
            @(negedge clk);
            if (freq_sel != last_f) begin
                pll_locked = 1'b0;
                lk = 5;
                last_f = freq_sel;
            end else if (lk > 0) begin
                lk--;
                if (lk == 0) pll_locked = 1'b1;
            end
        end
    end

    // monitor, sampled shortly after each rising edge
    int f_chg, v_first, v_last, done_cnt, stall_step_bad, en_bad;
    bit stall_seen, busy_seen;
    initial begin
        logic [4:0] pv;
        logic [2:0] pf;
        logic       ps;
        pv = 5'd19; pf = 3'd6; ps = 1'b0;
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            if (freq_sel != pf && f_chg < 0) f_chg = cyc;
            if (vstep_out != pv) begin
                if (v_first < 0) v_first = cyc;
                v_last = cyc;
                if (stall && ps) stall_step_bad++;
            end
            if (stall) stall_seen = 1;
            if (busy) busy_seen = 1;
            if (done) done_cnt++;
            if (clk_en == stall) en_bad++;
            pv = vstep_out; pf = freq_sel; ps = stall;
        end
    end

    task automatic clear_mon();
        f_chg = -1; v_first = -1; v_last = -1; done_cnt = 0;
        stall_seen = 0; busy_seen = 0; stall_step_bad = 0;
    endtask

    typedef struct packed {
        logic       relock;
        logic [7:0] dwell;
        logic [2:0] f;
        logic [4:0] v;
        logic [2:0] ef;
        logic [4:0] ev;
        logic [7:0] lat;   // 0 = latency not checked
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd3, 3'd4, 5'd16, 3'd4, 5'd16, 8'd11}, // R3 R5 lower freq, 3 steps
        '{1'b0, 8'd2, 3'd6, 5'd19, 3'd6, 5'd19, 8'd8},  // R4 raise freq after steps
        '{1'b0, 8'd1, 3'd7, 5'd25, 3'd6, 5'd19, 8'd1},  // R2 R9 clamped to current
        '{1'b0, 8'd4, 3'd0, 5'd31, 3'd1, 5'd19, 8'd2},  // R2 clamp, freq only
        '{1'b0, 8'd0, 3'd1, 5'd17, 3'd1, 5'd17, 8'd4},  // R5 dwell 0 acts as 1
        '{1'b1, 8'd2, 3'd3, 5'd18, 3'd3, 5'd18, 8'd0},  // R6 relock raise
        '{1'b1, 8'd2, 3'd2, 5'd16, 3'd2, 5'd16, 8'd0},  // R6 relock lower
        '{1'b0, 8'd2, 3'd2, 5'd14, 3'd2, 5'd14, 8'd6},  // R5 supply only
        '{1'b1, 8'd3, 3'd2, 5'd14, 3'd2, 5'd14, 8'd1},  // R9 equal in relock mode
        '{1'b0, 8'd1, 3'd5, 5'd19, 3'd5, 5'd19, 8'd7}   // R7 run-through raise
    };

    initial begin
        #(8 * 150000);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        clear_mon();
        en_bad = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(vstep_out == 5'd19, "R1 vstep", vstep_out, 19);
        chk(freq_sel == 3'd6, "R1 freq", freq_sel, 6);
        chk(!stall && !busy && !done, "R1 stall/busy/done", {stall, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t vv;
            int lat, prev_f, n_steps, d_eff;
            vv = VECS[i];
            prev_f = freq_sel;
            n_steps = (vstep_out > vv.ev) ? vstep_out - vv.ev : vv.ev - vstep_out;
            d_eff = (vv.dwell == 0) ? 1 : vv.dwell;
            clear_mon();
            req_freq = vv.f; req_vstep = vv.v; req_relock = vv.relock;
            dwell_cycles = {8'd0, vv.dwell};
            req_valid = 1'b1;
            lat = 0;
            forever begin
                @(posedge clk);
                lat++;
                @(negedge clk);
                if (lat == 1) req_valid = 1'b0;
                if (done || lat > 2000) break;
            end
            chk(done && !busy, "R8 done with busy low", {done, busy}, 2);
            chk(freq_sel == vv.ef, "R2 final freq", freq_sel, vv.ef);
            chk(vstep_out == vv.ev, "R5 final vstep", vstep_out, vv.ev);
            if (vv.lat != 0) chk(lat == vv.lat, "R8 latency", lat, vv.lat);
            if (!vv.relock) chk(!stall_seen, "R7 no stall", stall_seen, 0);
            if (vv.relock && vv.ef != prev_f) chk(stall_seen, "R6 stall raised", stall_seen, 1);
            chk(stall_step_bad == 0, "R6 no step in stall", stall_step_bad, 0);
            if (vv.lat == 1) chk(!busy_seen && !stall_seen, "R9 no busy", busy_seen, 0);
            if (vv.ef < prev_f && n_steps > 0)
                chk(f_chg < v_first, "R3 freq before step", f_chg, v_first);
            if (vv.ef > prev_f && n_steps > 0)
                chk(f_chg - v_last >= d_eff, "R4 freq after settle", f_chg - v_last, d_eff);
            repeat (3) @(negedge clk);
        end

        // R10 parked request, newest one wins
        clear_mon();
        dwell_cycles = 16'd2;
        req_relock = 1'b0;
        req_freq = 3'd5; req_vstep = 5'd15; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        repeat (2) @(negedge clk);
        req_freq = 3'd5; req_vstep = 5'd17; req_valid = 1'b1;
        @(negedge clk);
        req_freq = 3'd4; req_vstep = 5'd18;
        @(negedge clk); req_valid = 1'b0;
        for (int k = 0; k < 200; k++) @(negedge clk);
        chk(done_cnt == 2, "R10 completions", done_cnt, 2);
        chk(freq_sel == 3'd4, "R10 final freq", freq_sel, 4);
        chk(vstep_out == 5'd18, "R10 final vstep", vstep_out, 18);
        chk(en_bad == 0, "R6 clk_en inverse", en_bad, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule